// File: doc/BRIEF.md
# Stepper Phase Pattern Sequencer

This block produces the phase word for one bipolar stepper motor on a telescope's right-ascension axis. The motor is driven through a dual H-bridge. A separate rate timer issues single-cycle step-advance pulses, and each accepted pulse moves the block one entry through a code table. Switch inputs arrive already debounced, and all of them are active high.

When a pass through a table begins, the switches pick one of four modes:

- **Hold** leaves the output as it is.
- **Tracking** walks an eight-entry half-step table.
- **Forward slew** walks a four-entry full-step table first to last.
- **Reverse slew** walks the same four-entry table last to first.

A direction-swap switch inverts the two slew directions. A registered mode flag tells the rate timer whether to use the tracking interval or the slew interval. A build-time parameter mirrors the entry order of both tables, for use in the southern hemisphere.

Top module: `stepper_phase_seq`

## Requirements
- R1: A synchronous active-high reset clears `coil_word` to 0000000 and `slew_mode` to 0. The first step taken after reset loads the first entry of the walk order.
- R2: `coil_word` changes only on a rising clock edge at which `step_adv` is high. While `step_adv` is low it holds its value.
- R3: In tracking mode, successive steps with `SOUTH`=0 emit these half-step codes (bit 6 on the left): 0110110, 0101000, 0111010, 0010001, 0111001, 0100100, 0110101, 1010010. The sequence then repeats.
- R4: In forward slew with `SOUTH`=0, successive steps emit these full-step codes: 0110110, 0111010, 0111001, 1110101.
- R5: In reverse slew with `SOUTH`=0, the full-step codes are emitted last to first: 1110101, 0111001, 0111010, 0110110.
- R6: At the start of a pass, the switches are resolved in this order:
  - `sw_stop` first. It gives hold: no step is taken, the output is unchanged, and the next pulse re-evaluates the switches.
  - `sw_fwd` next, giving forward slew.
  - `sw_rev` after that, giving reverse slew.
  - Tracking when none of the three is set.
- R7: While `sw_swap` is high at the start of a pass, a forward request walks the reverse order and a reverse request walks the forward order.
- R8: Once a pass has begun it runs to completion, 8 steps for tracking and 4 for slew. Switch changes during the pass have no effect on the codes emitted.
- R9: `slew_mode` is 1 after a pass start that picked forward or reverse slew. It is 0 after a pass start that picked tracking or hold. It is unchanged inside a pass.
- R10: Bit 6 of `coil_word` is the indicator LED. It is set only for half-step code 1010010 and full-step code 1110101. Bits 5 and 4 are the bridge enables, and bits 3..0 are the coil inputs.
- R11: With `SOUTH`=1, every table is walked in mirrored order. Tracking starts at 1010010, forward slew starts at 1110101, and reverse slew starts at 0110110.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| step_adv | input | 1 | Single-cycle step-advance pulse from the rate timer |
| sw_stop | input | 1 | Stop switch; highest priority |
| sw_fwd | input | 1 | Forward slew request |
| sw_rev | input | 1 | Reverse slew request |
| sw_swap | input | 1 | Inverts the slew direction |
| coil_word | output | 7 | Registered word: LED, bridge enables, coil inputs |
| slew_mode | output | 1 | 1 selects the slew interval, 0 the tracking interval |

## Verification
The bench sweeps all sixteen combinations of the four switches, each for two passes. Before every step inside a pass it changes the switches, so a design that re-read them mid-pass would jump tables or truncate a pass and drift from the model. Combinations that assert several switches at once expose a wrong priority order or an ignored swap switch, because the resulting code sequence would differ. A second instance with mirrored order catches a design that mirrored only one table, or mirrored it off by one. Idle gaps between pulses catch an output that moves without a pulse. Stop-only starts catch a design that still advances the table on stop.

// File: rtl/seq_pkg.sv
package seq_pkg;
  localparam int WORD_W = 7;
  localparam int HALF_N = 8;
  localparam int FULL_N = 4;
  localparam int POS_W  = $clog2(HALF_N);

  typedef enum logic [1:0] {
    M_HOLD  = 2'd0,
    M_TRACK = 2'd1,
    M_FWD   = 2'd2,
    M_REV   = 2'd3
  } mode_t;
endpackage

// File: rtl/seq_mode_pick.sv
module seq_mode_pick
  import seq_pkg::*;
(
  input  logic  sw_stop,
  input  logic  sw_fwd,
  input  logic  sw_rev,
  input  logic  sw_swap,
  output mode_t pick
);
  always_comb begin
    if (sw_stop)
      pick = M_HOLD;
    else if (sw_fwd)
      pick = sw_swap ? M_REV : M_FWD;
    else if (sw_rev)
      pick = sw_swap ? M_FWD : M_REV;
    else
      pick = M_TRACK;
  end
endmodule

// File: rtl/seq_pass_ctr.sv
module seq_pass_ctr #(
  parameter int HALF_N = 8,
  parameter int FULL_N = 4,
  parameter int POS_W  = $clog2(HALF_N)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             adv,
  input  logic             is_track,
  output logic [POS_W-1:0] pos,
  output logic [POS_W-1:0] last,
  output logic             at_start
);
  localparam logic [POS_W-1:0] HALF_LAST = POS_W'(HALF_N - 1);
  localparam logic [POS_W-1:0] FULL_LAST = POS_W'(FULL_N - 1);

  assign last     = is_track ? HALF_LAST : FULL_LAST;
  assign at_start = (pos == '0);

  always_ff @(posedge clk) begin
    if (rst)
      pos <= '0;
    else if (adv)
      pos <= (pos == last) ? '0 : pos + 1'b1;
  end
endmodule

// File: rtl/seq_pattern_lut.sv
module seq_pattern_lut
  import seq_pkg::*;
(
  input  logic              is_track,
  input  logic [POS_W-1:0]  entry,
  output logic [WORD_W-1:0] code
);
  logic [WORD_W-1:0] half_code;
  logic [WORD_W-1:0] full_code;

  always_comb begin
    unique case (entry[2:0])
      3'd0: half_code = 7'b0110110;
      3'd1: half_code = 7'b0101000;
      3'd2: half_code = 7'b0111010;
      3'd3: half_code = 7'b0010001;
      3'd4: half_code = 7'b0111001;
      3'd5: half_code = 7'b0100100;
      3'd6: half_code = 7'b0110101;
      default: half_code = 7'b1010010;
    endcase
    unique case (entry[1:0])
      2'd0: full_code = 7'b0110110;
      2'd1: full_code = 7'b0111010;
      2'd2: full_code = 7'b0111001;
      default: full_code = 7'b1110101;
    endcase
    code = is_track ? half_code : full_code;
  end
endmodule

// File: rtl/stepper_phase_seq.sv
module stepper_phase_seq
  import seq_pkg::*;
#(
  parameter bit SOUTH = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              step_adv,
  input  logic              sw_stop,
  input  logic              sw_fwd,
  input  logic              sw_rev,
  input  logic              sw_swap,
  output logic [WORD_W-1:0] coil_word,
  output logic              slew_mode
);
  mode_t             pick;
  mode_t             cur_q;
  mode_t             use_mode;
  logic              at_start;
  logic              is_track;
  logic              step_ok;
  logic              walk_back;
  logic [POS_W-1:0]  pos;
  logic [POS_W-1:0]  last;
  logic [POS_W-1:0]  entry;
  logic [WORD_W-1:0] code;

  seq_mode_pick u_pick (
    .sw_stop (sw_stop),
    .sw_fwd  (sw_fwd),
    .sw_rev  (sw_rev),
    .sw_swap (sw_swap),
    .pick    (pick)
  );

  assign use_mode = at_start ? pick : cur_q;
  assign is_track = (use_mode == M_TRACK);
  assign step_ok  = step_adv && (use_mode != M_HOLD);

  seq_pass_ctr #(
    .HALF_N (HALF_N),
    .FULL_N (FULL_N),
    .POS_W  (POS_W)
  ) u_ctr (
    .clk      (clk),
    .rst      (rst),
    .adv      (step_ok),
    .is_track (is_track),
    .pos      (pos),
    .last     (last),
    .at_start (at_start)
  );

  generate
    if (SOUTH) begin : g_south
      assign walk_back = (use_mode != M_REV);
    end else begin : g_north
      assign walk_back = (use_mode == M_REV);
    end
  endgenerate

  assign entry = walk_back ? (last - pos) : pos;

  seq_pattern_lut u_lut (
    .is_track (is_track),
    .entry    (entry),
    .code     (code)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      coil_word <= '0;
      cur_q     <= M_HOLD;
      slew_mode <= 1'b0;
    end else if (step_adv) begin
      if (at_start) begin
        cur_q     <= pick;
        slew_mode <= (pick == M_FWD) || (pick == M_REV);
      end
      if (step_ok)
        coil_word <= code;
    end
  end
endmodule

// File: rtl/seq_chk.sv
module seq_chk (
  input logic       clk,
  input logic       rst,
  input logic       step_adv,
  input logic       sw_stop,
  input logic [6:0] coil_word,
  input logic       slew_mode,
  input logic       at_start
);
  // R1
  reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (coil_word == 7'd0) && !slew_mode);

  // R2
  idle_stable_chk: assert property (@(posedge clk) disable iff (rst)
    !step_adv |=> $stable(coil_word));

  // R6
  stop_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (step_adv && at_start && sw_stop) |=> $stable(coil_word) && at_start && !slew_mode);

  // R9
  mid_pass_mode_chk: assert property (@(posedge clk) disable iff (rst)
    (!at_start) |=> $stable(slew_mode));

  // R10
  led_code_chk: assert property (@(posedge clk) disable iff (rst)
    coil_word[6] |-> (coil_word[5:0] == 6'b010010) || (coil_word[5:0] == 6'b110101));

  // R10
  bridge_enable_chk: assert property (@(posedge clk) disable iff (rst)
    (coil_word != 7'd0) |-> (coil_word[5] || coil_word[4]));
endmodule

bind stepper_phase_seq seq_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .step_adv  (step_adv),
  .sw_stop   (sw_stop),
  .coil_word (coil_word),
  .slew_mode (slew_mode),
  .at_start  (at_start)
);

// File: tb/stepper_phase_seq_tb.sv
module stepper_phase_seq_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       step_adv = 1'b0;
  logic       sw_stop = 1'b0, sw_fwd = 1'b0, sw_rev = 1'b0, sw_swap = 1'b0;
  logic [6:0] word_n, word_s;
  logic       slew_n, slew_s;

  int checks = 0;
  int errors = 0;

  int         m_pos  = 0;
  int         m_mode = 0;
  logic [6:0] e_n = 7'd0, e_s = 7'd0;
  logic       e_slew = 1'b0;

  always #2 clk = ~clk;

  stepper_phase_seq #(.SOUTH(1'b0)) u_dut (
    .clk(clk), .rst(rst), .step_adv(step_adv), .sw_stop(sw_stop), .sw_fwd(sw_fwd),
    .sw_rev(sw_rev), .sw_swap(sw_swap), .coil_word(word_n), .slew_mode(slew_n));

  stepper_phase_seq #(.SOUTH(1'b1)) u_south (
    .clk(clk), .rst(rst), .step_adv(step_adv), .sw_stop(sw_stop), .sw_fwd(sw_fwd),
    .sw_rev(sw_rev), .sw_swap(sw_swap), .coil_word(word_s), .slew_mode(slew_s));

  function automatic logic [6:0] half_code(input int i);
    case (i)
      0: return 7'b0110110; 1: return 7'b0101000; 2: return 7'b0111010; 3: return 7'b0010001;
      4: return 7'b0111001; 5: return 7'b0100100; 6: return 7'b0110101; default: return 7'b1010010;
    endcase
  endfunction

  function automatic logic [6:0] full_code(input int i);
    case (i)
      0: return 7'b0110110; 1: return 7'b0111010; 2: return 7'b0111001; default: return 7'b1110101;
    endcase
  endfunction

  task automatic check(input string tag, input logic [6:0] act, input logic [6:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic do_step(input logic [3:0] sw, input bit mid);
    string tag;
    int    len;
    int    k_n, k_s;
    @(negedge clk);
    {sw_swap, sw_rev, sw_fwd, sw_stop} = sw;
    if (m_pos == 0) begin
      if (sw[0])      m_mode = 0;
      else if (sw[1]) m_mode = sw[3] ? 3 : 2;
      else if (sw[2]) m_mode = sw[3] ? 2 : 3;
      else            m_mode = 1;
      e_slew = (m_mode >= 2);
    end
    if (mid)                       tag = "R8";
    else if (m_mode == 0)          tag = "R6";
    else if (sw[3] && m_mode >= 2) tag = "R7";
    else if (m_mode == 1)          tag = "R3";
    else if (m_mode == 2)          tag = "R4";
    else                           tag = "R5";
    if (m_mode != 0) begin
      len = (m_mode == 1) ? 8 : 4;
      k_n = (m_mode == 3) ? len - 1 - m_pos : m_pos;
      k_s = len - 1 - k_n;
      e_n = (m_mode == 1) ? half_code(k_n) : full_code(k_n);
      e_s = (m_mode == 1) ? half_code(k_s) : full_code(k_s);
      m_pos = (m_pos == len - 1) ? 0 : m_pos + 1;
    end
    step_adv = 1'b1;
    @(negedge clk);
    step_adv = 1'b0;
    check(tag, word_n, e_n);
    check("R11", word_s, e_s);
    check("R9", {6'd0, slew_n}, {6'd0, e_slew});
    check("R10", {6'd0, word_n[6]}, {6'd0, (e_n == 7'b1010010) || (e_n == 7'b1110101)});
  endtask

  initial begin
    #100000;
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1", word_n, 7'd0);
    check("R1", word_s, 7'd0);
    check("R1", {6'd0, slew_n}, 7'd0);
    for (int c = 0; c < 16; c++) begin
      for (int rep = 0; rep < 2; rep++) begin
        do_step(4'(c), 1'b0);
        for (int k = 0; m_pos != 0; k++)
          do_step(4'(c + 5 + k), 1'b1);
        repeat (3) @(negedge clk);
        // R2 no change without a pulse
        check("R2", word_n, e_n);
        check("R2", word_s, e_s);
      end
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule